// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block sits between instruction decode and the operand path of a small processor. Decode presents a 4-bit mode code, the instruction's 8-bit address field, the program counter (already stepped past the current instruction), the contents of the register selected by the instruction, and the dedicated index and base registers. It then pulses `start`. The generator returns either a 16-bit effective address or, in immediate mode, the operand itself. It marks the result with a one-cycle `ea_valid` strobe.

Memory-indirect mode needs one extra trip to memory. The block issues a read request to a synchronous memory, waits for the returned word and delivers that word as the address. The auto-increment and auto-decrement modes also emit a write-back request carrying the stepped register value, and the register file applies it. Codes outside the defined set are answered with an illegal-mode flag, not an address.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output is zero: `ea_valid`, `mem_rd_en`, `wb_en`, `illegal`, `is_operand`, `no_addr`, `ea_out`, `mem_raddr` and `wb_data`.
- R2: For every mode except memory-indirect (code 7), an accepted `start` raises `ea_valid` for exactly one cycle, in the cycle after the start edge.
- R3: Memory-indirect (code 7). In the cycle after start, `mem_rd_en` is high for one cycle with `mem_raddr` equal to the zero-extended field. The memory answers on `mem_rdata` one cycle later. `ea_out` takes that word with `ea_valid` high in the third cycle after start, and `ea_valid` stays low in the two cycles before.
- R4: Direct (code 6) gives `ea_out` equal to the zero-extended field. Immediate (code 0) gives the zero-extended field with `is_operand` high.
- R5: Relative (code 8) gives `pc_next` plus the sign-extended field, modulo 2^16.
- R6: Indexed (code 9) gives `idx_data` plus the zero-extended field. Base (code 10) gives `base_data` plus the zero-extended field. Both wrap modulo 2^16.
- R7: Register-indirect (code 3) gives `ea_out` equal to `reg_data`, with `wb_en` low.
- R8: Auto-increment (code 4) and auto-decrement (code 5) give `ea_out` equal to `reg_data`, which is the value before stepping. In the same cycle they raise `wb_en` with `wb_data` equal to `reg_data` plus one or minus one, modulo 2^16.
- R9: Implied (code 1) and register (code 2) raise `no_addr` with `ea_out` zero. At most one of `is_operand`, `no_addr` and `illegal` is high at a time.
- R10: Codes 11 to 15 raise `illegal` together with `ea_valid`. `ea_out` is zero, and no memory read and no write-back is made.
- R11: A `start` that arrives in the two cycles after an accepted memory-indirect start is ignored. No extra strobe and no change to the delivered result follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing mode code |
| field | input | 8 | Address field of the instruction |
| pc_next | input | 16 | Program counter after increment |
| reg_data | input | 16 | Contents of the register named by the instruction |
| idx_data | input | 16 | Index register |
| base_data | input | 16 | Base register |
| mem_rd_en | output | 1 | Memory read request (indirect mode) |
| mem_raddr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| ea_valid | output | 1 | Result strobe |
| ea_out | output | 16 | Effective address or immediate operand |
| is_operand | output | 1 | `ea_out` carries an operand, not an address |
| no_addr | output | 1 | Mode produces no memory address |
| illegal | output | 1 | Undefined mode code |
| wb_en | output | 1 | Register write-back request |
| wb_data | output | 16 | Stepped register value to write back |

## Verification
Two of the block's functions land in the same cycle: the write-back request of the auto-step modes and the result strobe. Tests at the wrap corners (0xFFFF stepped up, 0x0000 stepped down) judge both values sampled together in that one cycle. The second collision is a new `start`, held high through the wait of a memory-indirect access. The check confirms that exactly one strobe appears, that it carries the memory word and not the direct-mode address presented meanwhile, and that no further strobe follows.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_IMPL = 4'd1,
    M_REG  = 4'd2,
    M_RIND = 4'd3,
    M_AINC = 4'd4,
    M_ADEC = 4'd5,
    M_DIR  = 4'd6,
    M_MIND = 4'd7,
    M_REL  = 4'd8,
    M_IDX  = 4'd9,
    M_BASE = 4'd10
  } ea_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_calc.sv
`timescale 1ns/1ps
module ea_calc #(
  parameter int AW = 16,
  parameter int FW = 8
) (
  input  logic [3:0]    mode,
  input  logic [FW-1:0] field,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] reg_data,
  input  logic [AW-1:0] idx_data,
  input  logic [AW-1:0] base_data,
  output logic [AW-1:0] addr,
  output logic          is_op,
  output logic          no_addr,
  output logic          needs_mem,
  output logic          bad_mode,
  output logic          wb_req,
  output logic [AW-1:0] wb_val
);
  import ea_pkg::*;

  logic [AW-1:0] fz;
  logic [AW-1:0] fs;

  generate
    if (AW > FW) begin : g_ext
      assign fz = {{(AW-FW){1'b0}}, field};
      assign fs = {{(AW-FW){field[FW-1]}}, field};
    end else begin : g_same
      assign fz = field[AW-1:0];
      assign fs = field[AW-1:0];
    end
  endgenerate

  always_comb begin
    addr      = '0;
    is_op     = 1'b0;
    no_addr   = 1'b0;
    needs_mem = 1'b0;
    bad_mode  = 1'b0;
    wb_req    = 1'b0;
    wb_val    = reg_data;
    case (mode)
      M_IMM:  begin addr = fz; is_op = 1'b1; end
      M_IMPL,
      M_REG:  no_addr = 1'b1;
      M_RIND: addr = reg_data;
      M_AINC: begin addr = reg_data; wb_req = 1'b1; wb_val = reg_data + AW'(1); end
      M_ADEC: begin addr = reg_data; wb_req = 1'b1; wb_val = reg_data - AW'(1); end
      M_DIR:  addr = fz;
      M_MIND: begin addr = fz; needs_mem = 1'b1; end
      M_REL:  addr = pc_next + fs;
      M_IDX:  addr = idx_data + fz;
      M_BASE: addr = base_data + fz;
      default: bad_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
`timescale 1ns/1ps
module ea_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] c_addr,
  input  logic          c_is_op,
  input  logic          c_no_addr,
  input  logic          c_mem,
  input  logic          c_bad,
  input  logic          c_wb,
  input  logic [AW-1:0] c_wb_val,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_raddr,
  output logic          ea_valid,
  output logic [AW-1:0] ea_out,
  output logic          is_operand,
  output logic          no_addr,
  output logic          illegal,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          busy
);
  import ea_pkg::*;

  ea_state_e st;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      mem_rd_en  <= 1'b0;
      mem_raddr  <= '0;
      ea_valid   <= 1'b0;
      ea_out     <= '0;
      is_operand <= 1'b0;
      no_addr    <= 1'b0;
      illegal    <= 1'b0;
      wb_en      <= 1'b0;
      wb_data    <= '0;
    end else begin
      mem_rd_en  <= 1'b0;
      ea_valid   <= 1'b0;
      is_operand <= 1'b0;
      no_addr    <= 1'b0;
      illegal    <= 1'b0;
      wb_en      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (c_mem) begin
              mem_rd_en <= 1'b1;
              mem_raddr <= c_addr;
              st        <= S_REQ;
            end else begin
              ea_valid   <= 1'b1;
              ea_out     <= c_addr;
              is_operand <= c_is_op;
              no_addr    <= c_no_addr;
              illegal    <= c_bad;
              wb_en      <= c_wb;
              if (c_wb) wb_data <= c_wb_val;
            end
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          ea_valid <= 1'b1;
          ea_out   <= mem_rdata;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
`timescale 1ns/1ps
module eff_addr_gen #(
  parameter int AW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [FW-1:0] field,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] reg_data,
  input  logic [AW-1:0] idx_data,
  input  logic [AW-1:0] base_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_raddr,
  input  logic [AW-1:0] mem_rdata,
  output logic          ea_valid,
  output logic [AW-1:0] ea_out,
  output logic          is_operand,
  output logic          no_addr,
  output logic          illegal,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  logic [AW-1:0] c_addr;
  logic [AW-1:0] c_wb_val;
  logic          c_is_op;
  logic          c_no_addr;
  logic          c_mem;
  logic          c_bad;
  logic          c_wb;
  logic          busy;

  ea_calc #(.AW(AW), .FW(FW)) u_calc (
    .mode      (mode),
    .field     (field),
    .pc_next   (pc_next),
    .reg_data  (reg_data),
    .idx_data  (idx_data),
    .base_data (base_data),
    .addr      (c_addr),
    .is_op     (c_is_op),
    .no_addr   (c_no_addr),
    .needs_mem (c_mem),
    .bad_mode  (c_bad),
    .wb_req    (c_wb),
    .wb_val    (c_wb_val)
  );

  ea_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .c_addr     (c_addr),
    .c_is_op    (c_is_op),
    .c_no_addr  (c_no_addr),
    .c_mem      (c_mem),
    .c_bad      (c_bad),
    .c_wb       (c_wb),
    .c_wb_val   (c_wb_val),
    .mem_rdata  (mem_rdata),
    .mem_rd_en  (mem_rd_en),
    .mem_raddr  (mem_raddr),
    .ea_valid   (ea_valid),
    .ea_out     (ea_out),
    .is_operand (is_operand),
    .no_addr    (no_addr),
    .illegal    (illegal),
    .wb_en      (wb_en),
    .wb_data    (wb_data),
    .busy       (busy)
  );
endmodule

// File: rtl/eff_addr_gen_chk.sv
`timescale 1ns/1ps
module eff_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    mode,
  input logic          busy,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rdata,
  input logic          ea_valid,
  input logic [AW-1:0] ea_out,
  input logic          is_operand,
  input logic          no_addr,
  input logic          illegal,
  input logic          wb_en,
  input logic [AW-1:0] wb_data
);
  // R2: accepted non-indirect start strobes next cycle
  p_strobe_next_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode != 4'd7) |=> ea_valid);

  // R3: indirect start requests memory and holds the strobe back
  p_ind_request_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 4'd7) |=> (mem_rd_en && !ea_valid));

  // R3: request is a single-cycle pulse
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R3: the returned word becomes the result
  p_ind_result_r3: assert property (@(posedge clk) disable iff (rst)
    $past(mem_rd_en, 2) |-> (ea_valid && ea_out == $past(mem_rdata)));

  // R8: write-back only alongside the strobe, stepped by one
  p_wb_step_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (ea_valid && (wb_data == ea_out + AW'(1) || wb_data == ea_out - AW'(1))));

  // R9: result kind flags are exclusive
  p_kind_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_operand, no_addr, illegal}));

  // R10: illegal answer carries no address and no write-back
  p_illegal_clean_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (ea_valid && ea_out == '0 && !wb_en && !mem_rd_en));
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mode       (mode),
  .busy       (busy),
  .mem_rd_en  (mem_rd_en),
  .mem_rdata  (mem_rdata),
  .ea_valid   (ea_valid),
  .ea_out     (ea_out),
  .is_operand (is_operand),
  .no_addr    (no_addr),
  .illegal    (illegal),
  .wb_en      (wb_en),
  .wb_data    (wb_data)
);

// File: tb/tb_eff_addr_gen.sv
`timescale 1ns/1ps
module tb_eff_addr_gen;
  localparam int AW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    mode = 4'd0;
  logic [FW-1:0] field = '0;
  logic [AW-1:0] pc_next = '0;
  logic [AW-1:0] reg_data = '0;
  logic [AW-1:0] idx_data = '0;
  logic [AW-1:0] base_data = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_raddr;
  logic [AW-1:0] mem_rdata = '0;
  logic          ea_valid;
  logic [AW-1:0] ea_out;
  logic          is_operand;
  logic          no_addr;
  logic          illegal;
  logic          wb_en;
  logic [AW-1:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eff_addr_gen #(.AW(AW), .FW(FW)) dut (.*);

  function automatic logic [AW-1:0] memf(input logic [AW-1:0] a);
    return a * 16'd7 + 16'h1234;
  endfunction

  // synchronous memory model: data one cycle after the request
  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_raddr);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drives one start pulse; returns at the negedge after the start edge
  task automatic issue(input logic [3:0] m, input logic [FW-1:0] f);
    @(negedge clk);
    mode = m; field = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "valid", ea_valid, 0);
    chk("R1", "mem_rd_en", mem_rd_en, 0);
    chk("R1", "wb_en", wb_en, 0);
    chk("R1", "flags", {illegal, is_operand, no_addr}, 0);
    chk("R1", "ea_out", ea_out, 0);
    chk("R1", "mem_raddr", mem_raddr, 0);
    chk("R1", "wb_data", wb_data, 0);
  endtask

  task automatic t_direct_imm();
    issue(4'd6, 8'hC8);
    chk("R2", "direct valid", ea_valid, 1);
    chk("R4", "direct ea", ea_out, 16'h00C8);
    chk("R4", "direct not operand", is_operand, 0);
    @(negedge clk);
    chk("R2", "single-cycle strobe", ea_valid, 0);
    issue(4'd0, 8'h9A);
    chk("R4", "imm ea", ea_out, 16'h009A);
    chk("R4", "imm is_operand", is_operand, 1);
  endtask

  task automatic t_relative();
    pc_next = 16'd826;
    issue(4'd8, 8'd24);
    chk("R5", "rel forward", ea_out, 16'd850);
    pc_next = 16'h0005;
    issue(4'd8, 8'hF0);
    chk("R5", "rel backward wrap", ea_out, 16'hFFF5);
  endtask

  task automatic t_index_base();
    idx_data = 16'h1000; base_data = 16'hFFF0;
    issue(4'd9, 8'h80);
    chk("R6", "indexed", ea_out, 16'h1080);
    issue(4'd10, 8'h20);
    chk("R6", "base wrap", ea_out, 16'h0010);
  endtask

  task automatic t_reg_ind();
    reg_data = 16'hBEEF;
    issue(4'd3, 8'h00);
    chk("R7", "reg-indirect ea", ea_out, 16'hBEEF);
    chk("R7", "no write-back", wb_en, 0);
  endtask

  task automatic t_auto();
    reg_data = 16'hFFFF;
    issue(4'd4, 8'h00);
    chk("R8", "inc ea", ea_out, 16'hFFFF);
    chk("R8", "inc wb_en+valid", {wb_en, ea_valid}, 2'b11);
    chk("R8", "inc wb_data wrap", wb_data, 16'h0000);
    reg_data = 16'h0000;
    issue(4'd5, 8'h00);
    chk("R8", "dec ea", ea_out, 16'h0000);
    chk("R8", "dec wb_en", wb_en, 1);
    chk("R8", "dec wb_data wrap", wb_data, 16'hFFFF);
    @(negedge clk);
    chk("R8", "wb pulse ends", wb_en, 0);
  endtask

  task automatic t_impl_reg();
    issue(4'd1, 8'h55);
    chk("R9", "implied no_addr", {no_addr, ea_out}, {1'b1, 16'h0000});
    issue(4'd2, 8'h55);
    chk("R9", "register no_addr", {no_addr, is_operand, ea_out}, {2'b10, 16'h0000});
  endtask

  task automatic t_illegal();
    for (int c = 11; c < 16; c++) begin
      issue(4'(c), 8'h77);
      chk("R10", "illegal flag+valid", {illegal, ea_valid}, 2'b11);
      chk("R10", "illegal ea/wb/mem", {ea_out, wb_en, mem_rd_en}, 18'h0);
    end
  endtask

  task automatic t_indirect();
    issue(4'd7, 8'h3B);
    chk("R3", "request issued", mem_rd_en, 1);
    chk("R3", "request addr", mem_raddr, 16'h003B);
    chk("R3", "no strobe yet", ea_valid, 0);
    @(negedge clk);
    chk("R3", "request ends", mem_rd_en, 0);
    chk("R3", "still waiting", ea_valid, 0);
    @(negedge clk);
    chk("R3", "strobe", ea_valid, 1);
    chk("R3", "ea from memory", ea_out, memf(16'h003B));
  endtask

  task automatic t_busy();
    issue(4'd7, 8'h12);
    mode = 4'd6; field = 8'h55; start = 1'b1;
    @(negedge clk);
    chk("R11", "no strobe while busy", ea_valid, 0);
    @(negedge clk);
    chk("R11", "single strobe", ea_valid, 1);
    chk("R11", "indirect result kept", ea_out, memf(16'h0012));
    start = 1'b0;
    @(negedge clk);
    chk("R11", "ignored start gives no strobe", ea_valid, 0);
    chk("R11", "result unchanged", ea_out, memf(16'h0012));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct_imm();
    t_relative();
    t_index_base();
    t_reg_ind();
    t_auto();
    t_impl_reg();
    t_illegal();
    t_indirect();
    t_busy();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule